// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter that a system must service periodically to show it is still executing correctly. A small write port reaches two registers: a mode register that holds the run enable, a 3-bit period select, an idle-run permission and a bit that chooses the overflow action, and a write-only key register. Writing one key value restarts the count from zero. A second key value also restarts the count, and it halts the watchdog only if the mode register's enable bit is already low. Because two separate writes are needed, a program that has lost control is unlikely to switch the watchdog off by accident.

The count advances once per clock while the watchdog runs. It is paused during a stop power state, and during an idle power state unless the idle-run permission is set. When the count reaches the selected limit, the block gives a one-cycle request and the count restarts from zero. The request goes to the reset output when the overflow-action bit is set, and to the non-maskable interrupt output when it is clear. The period is 2^(BASE_TAP + 2*sel) running cycles. BASE_TAP defaults to 15, which gives 2^15 to 2^29 cycles.

Top module: `wdt_keyed`

## Requirements
- R1: While reset is asserted and directly after it, mode_rd reads 0x21 (enabled, period select 0, idle-run permission 0, overflow action = reset), and both request outputs are low.
- R2: With period select s, a request pulse appears exactly 2^(BASE_TAP+2*s) running cycles after the count was last zero. The count is zero at reset release and at the clock edge that accepts a key write.
- R3: An overflow gives rst_req when mode bit 5 is 1 and nmi_req when it is 0. The two are never high together.
- R4: Each request is high for exactly one cycle. The count then restarts, so the next request follows one full period later.
- R5: Writing 0x4E to the key register (wr_addr = 1) sets the count to zero. A request that would have fired on that same edge is dropped.
- R6: Writing 0xB1 to the key register while mode bit 0 is 0 halts the watchdog. No further requests appear.
- R7: Clearing mode bit 0 on its own leaves the watchdog counting and firing.
- R8: Writing 0xB1 while mode bit 0 is 1 only sets the count to zero. The watchdog keeps running.
- R9: A mode write with bit 0 set restarts a halted watchdog without any key. Counting resumes from zero on the following edge.
- R10: While idle_i is high, the count pauses if mode bit 4 is 0 and keeps running if it is 1.
- R11: While stop_i is high, the count is frozen and no request is given.
- R12: Key register writes of any value other than 0x4E or 0xB1 have no effect on the count, the timing of requests or the mode register.
- R13: A mode write (wr_addr = 0) stores wr_data[5:0] with this layout: bit 0 enable, bits 3:1 period select, bit 4 idle-run permission, bit 5 overflow action. The change is visible on mode_rd after the next edge, and bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the mode register, 1 selects the key register |
| wr_data | input | 8 | Write data |
| idle_i | input | 1 | Idle power state is active |
| stop_i | input | 1 | Stop power state is active |
| mode_rd | output | 8 | Current mode register contents |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request on overflow |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The bench runs with a small BASE_TAP so that each period lasts tens of cycles. It predicts every request pulse to the exact cycle, which catches an off-by-one limit, a missed restart after a pulse, or pulses routed to the wrong output. It clears the enable bit without a key, and writes the halt key with the enable bit high. A design that accepted either key alone as a halt would go silent when it should keep firing. It also holds idle and stop for known spans and expects each pulse to move later by that amount, or not to move when idle-run is permitted. A design that ignored the power inputs, or ignored the idle-run permission, would fire early. Junk key values must leave the pulse schedule untouched.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

   typedef struct packed {
      logic       rst_link;   // 1: overflow requests reset, 0: nmi
      logic       idle_run;   // count during idle power state
      logic [2:0] sel;        // period select
      logic       en;         // run enable
   } wdt_mode_t;

   localparam int MODE_W = $bits(wdt_mode_t);

   localparam wdt_mode_t MODE_RST = '{rst_link: 1'b1, idle_run: 1'b0,
                                      sel: 3'd0, en: 1'b1};

   typedef enum logic {
      WA_MODE = 1'b0,
      WA_KEY  = 1'b1
   } wdt_addr_e;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_keyed_pkg::*;
#(
   parameter logic [7:0] KEY_CLR = 8'h4E,
   parameter logic [7:0] KEY_OFF = 8'hB1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic      wr_addr,
   input  logic [7:0] wr_data,
   output wdt_mode_t mode_q,
   output logic      run_q,
   output logic      cnt_clr
);

   logic mode_wr;
   logic key_wr;
   logic key_clr_hit;
   logic key_off_hit;

   always_comb begin
      mode_wr     = wr_en && (wr_addr == WA_MODE);
      key_wr      = wr_en && (wr_addr == WA_KEY);
      key_clr_hit = key_wr && (wr_data == KEY_CLR);
      key_off_hit = key_wr && (wr_data == KEY_OFF);
      cnt_clr     = key_clr_hit || key_off_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
      end else if (mode_wr) begin
         mode_q <= wdt_mode_t'(wr_data[MODE_W-1:0]);
      end
   end

   // halt needs both the enable bit low and the off key
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b1;
      end else if (mode_wr && wr_data[0]) begin
         run_q <= 1'b1;
      end else if (key_off_hit && !mode_q.en) begin
         run_q <= 1'b0;
      end
   end

   logic unused_hi;
   assign unused_hi = ^wr_data[7:MODE_W];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int BASE_TAP = 15,
   parameter int STEPS    = 8,
   localparam int SEL_W   = $clog2(STEPS),
   localparam int CW      = BASE_TAP + 2 * (STEPS - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             ovf
);

   logic [CW-1:0]    cnt_q;
   logic [STEPS-1:0] tap_hit;

   // one tap per period step: all low bits of that step set
   for (genvar gi = 0; gi < STEPS; gi++) begin : g_tap
      localparam int T = BASE_TAP + 2 * gi;
      assign tap_hit[gi] = &cnt_q[T-1:0];
   end

   logic at_limit;
   assign at_limit = tap_hit[sel];
   assign ovf      = active && !clr && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (active) begin
         if (at_limit) cnt_q <= '0;
         else          cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdt_fire.sv
module wdt_fire (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf,
   input  logic rst_link,
   output logic nmi_q,
   output logic rst_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         nmi_q <= ovf && !rst_link;
         rst_q <= ovf && rst_link;
      end
   end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_keyed_pkg::*;
#(
   parameter int         BASE_TAP = 15,
   parameter logic [7:0] KEY_CLR  = 8'h4E,
   parameter logic [7:0] KEY_OFF  = 8'hB1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_addr,
   input  logic [7:0] wr_data,
   input  logic       idle_i,
   input  logic       stop_i,
   output logic [7:0] mode_rd,
   output logic       nmi_req,
   output logic       rst_req
);

   localparam int STEPS = 8;

   if (BASE_TAP < 1) begin : g_bad_tap
      $error("wdt_keyed: BASE_TAP must be at least 1");
   end
   if (KEY_CLR == KEY_OFF) begin : g_bad_keys
      $error("wdt_keyed: the two key values must differ");
   end

   wdt_mode_t mode_q;
   logic      run_q;
   logic      cnt_clr;
   logic      active;
   logic      ovf;

   wdt_regs #(
      .KEY_CLR (KEY_CLR),
      .KEY_OFF (KEY_OFF)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .mode_q  (mode_q),
      .run_q   (run_q),
      .cnt_clr (cnt_clr)
   );

   assign active = run_q && !stop_i && (!idle_i || mode_q.idle_run);

   wdt_counter #(
      .BASE_TAP (BASE_TAP),
      .STEPS    (STEPS)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .clr    (cnt_clr),
      .sel    (mode_q.sel),
      .ovf    (ovf)
   );

   wdt_fire u_fire (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf      (ovf),
      .rst_link (mode_q.rst_link),
      .nmi_q    (nmi_req),
      .rst_q    (rst_req)
   );

   assign mode_rd = {{(8 - MODE_W){1'b0}}, mode_q};

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
   parameter logic [7:0] KEY_CLR = 8'h4E,
   parameter logic [7:0] KEY_OFF = 8'hB1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       wr_addr,
   input logic [7:0] wr_data,
   input logic       stop_i,
   input logic [7:0] mode_rd,
   input logic       nmi_req,
   input logic       rst_req
);

   logic key_hit;
   assign key_hit = wr_en && wr_addr && ((wr_data == KEY_CLR) || (wr_data == KEY_OFF));

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_req && rst_req)); // R3

   AST_NMI_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> !$past(mode_rd[5])); // R3

   AST_RST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(mode_rd[5])); // R3

   AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> !nmi_req); // R4

   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R4

   AST_KEY_DROPS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> (!nmi_req && !rst_req)); // R5

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!nmi_req && !rst_req)); // R11

   AST_MODE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr) |=> (mode_rd == {2'b00, $past(wr_data[5:0])})); // R13

endmodule

bind wdt_keyed wdt_keyed_chk #(
   .KEY_CLR (KEY_CLR),
   .KEY_OFF (KEY_OFF)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .stop_i  (stop_i),
   .mode_rd (mode_rd),
   .nmi_req (nmi_req),
   .rst_req (rst_req)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;

   localparam int BT = 3;
   localparam int P0 = 8;    // 2^(3+0)
   localparam int P1 = 32;   // 2^(3+2)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       idle_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] mode_rd;
   logic       nmi_req;
   logic       rst_req;

   always #10 clk = ~clk;   // 50 MHz

   wdt_keyed #(.BASE_TAP(BT)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .idle_i  (idle_i),
      .stop_i  (stop_i),
      .mode_rd (mode_rd),
      .nmi_req (nmi_req),
      .rst_req (rst_req)
   );

   typedef struct {
      int    at;
      bit    is_rst;
      string req;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   total = 0;
   int   bad = 0;
   int   seen = 0;
   int   last_k = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic push(input int at, input bit is_rst, input string req);
      exp_t e;
      e.at = at; e.is_rst = is_rst; e.req = req;
      q.push_back(e);
   endtask

   // called at a negedge; the write is taken on the next rising edge
   task automatic wr(input bit addr, input logic [7:0] data);
      wr_en = 1'b1; wr_addr = addr; wr_data = data; last_k = cyc;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (nmi_req || rst_req) seen++;
         if (q.size() > 0 && q[0].at == cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.is_rst)
               chk(rst_req && !nmi_req, e.req, "rst pulse", {nmi_req, rst_req}, 2'b01);
            else
               chk(nmi_req && !rst_req, e.req, "nmi pulse", {nmi_req, rst_req}, 2'b10);
         end else if (nmi_req || rst_req) begin
            chk(1'b0, "R2", "unexpected pulse", {nmi_req, rst_req}, 0);
         end
         while (q.size() > 0 && q[0].at < cyc) begin
            exp_t m;
            m = q.pop_front();
            chk(1'b0, m.req, "missed pulse at cycle", cyc, m.at);
         end
      end
   end

   task automatic finish_up();
      done = 1'b1;
      while (q.size() > 0) begin
         exp_t m;
         m = q.pop_front();
         chk(1'b0, m.req, "pulse never seen", 0, m.at);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R2", "watchdog expired", cyc, 0);
      finish_up();
   end

   initial begin
      int t0;
      int s;
      repeat (3) @(negedge clk);
      chk(mode_rd == 8'h21, "R1", "mode in reset", mode_rd, 8'h21);
      chk(!nmi_req && !rst_req, "R1", "requests in reset", {nmi_req, rst_req}, 0);
      rst_n = 1'b1;
      t0 = cyc;
      @(negedge clk);
      chk(mode_rd == 8'h21, "R13", "mode after reset", mode_rd, 8'h21);

      // R2 R3 R4: reset defaults fire reset pulses every P0
      push(t0 + P0, 1'b1, "R2");
      push(t0 + 2 * P0, 1'b1, "R4");
      push(t0 + 3 * P0, 1'b1, "R3");
      wait_to(t0 + 3 * P0 + 2);

      // R5: clear key restarts the count
      wr(1'b1, 8'h4E);
      t0 = last_k + 1;
      push(t0 + P0, 1'b1, "R5");
      wait_to(t0 + P0 + 1);

      // R12: junk keys leave the schedule and mode alone
      wr(1'b1, 8'h55);
      wr(1'b1, 8'h00);
      wr(1'b1, 8'hB0);
      push(t0 + 2 * P0, 1'b1, "R12");
      chk(mode_rd == 8'h21, "R12", "mode after junk keys", mode_rd, 8'h21);
      wait_to(t0 + 2 * P0 + 1);

      // R13 R3 R2: nmi routing, period select 1
      wr(1'b0, 8'h03);
      chk(mode_rd == 8'h03, "R13", "mode readback", mode_rd, 8'h03);
      wr(1'b1, 8'h4E);
      t0 = last_k + 1;
      push(t0 + P1, 1'b0, "R3");
      push(t0 + 2 * P1, 1'b0, "R2");
      wait_to(t0 + 2 * P1 + 1);

      // R7: enable bit low alone keeps counting
      wr(1'b0, 8'h02);
      wr(1'b1, 8'h4E);
      t0 = last_k + 1;
      push(t0 + P1, 1'b0, "R7");
      wait_to(t0 + P1 + 1);

      // R6: off key with enable low halts
      wr(1'b1, 8'hB1);
      s = seen;
      repeat (100) @(negedge clk);
      chk(seen == s, "R6", "pulses while halted", seen - s, 0);

      // R9: enable bit restores running from zero
      wr(1'b0, 8'h03);
      t0 = last_k + 1;
      push(t0 + P1, 1'b0, "R9");
      wait_to(t0 + P1 + 1);

      // R8: off key with enable high only clears
      repeat (10) @(negedge clk);
      wr(1'b1, 8'hB1);
      t0 = last_k + 1;
      push(t0 + P1, 1'b0, "R8");
      push(t0 + 2 * P1, 1'b0, "R8");
      wait_to(t0 + 2 * P1 + 1);

      // R10: idle pauses when not permitted
      wr(1'b1, 8'h4E);
      t0 = last_k + 1;
      push(t0 + P1 + 20, 1'b0, "R10");
      wait_to(t0 + 5);
      idle_i = 1'b1;
      repeat (20) @(negedge clk);
      idle_i = 1'b0;
      wait_to(t0 + P1 + 21);

      // R10: idle ignored when permitted
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h4E);
      t0 = last_k + 1;
      push(t0 + P1, 1'b0, "R10");
      idle_i = 1'b1;
      wait_to(t0 + P1 + 1);
      idle_i = 1'b0;

      // R11: stop freezes the count
      wr(1'b1, 8'h4E);
      t0 = last_k + 1;
      push(t0 + P1 + 15, 1'b0, "R11");
      wait_to(t0 + 3);
      stop_i = 1'b1;
      repeat (15) @(negedge clk);
      stop_i = 1'b0;
      wait_to(t0 + P1 + 16);

      // R3: back to reset routing, period select 0
      wr(1'b0, 8'h21);
      wr(1'b1, 8'h4E);
      t0 = last_k + 1;
      push(t0 + P0, 1'b1, "R3");
      push(t0 + 2 * P0, 1'b1, "R4");
      wait_to(t0 + 2 * P0 + 2);

      finish_up();
   end

endmodule